// File: doc/BRIEF.md
# I2C Register Target with Strap-Selected Address

This block is an I2C target that runs entirely on the system clock. It oversamples the SCL and SDA lines through synchronizers and decodes bus events from them. Its 7-bit address has five fixed upper bits, `10010`. The two lowest bits come from one strap pin, which the board can connect to ground, to the supply, to the SDA line or to the SCL line. The block acknowledges every byte it receives. It holds a small register file that the bus master writes and reads through an auto-incrementing pointer.

A write transaction carries the target address with R/W = 0. The first byte after it loads the register pointer. Every later byte writes the register at the pointer, raises a one-cycle write strobe, and then advances the pointer. To read, the master writes the pointer, issues a repeated START and sends the address with R/W = 1. The block then returns one register per byte for as long as the master acknowledges. The block drives SDA only through an open-drain pull-down enable. A STOP that falls in the same SCL high phase as the START before it is treated as illegal and is ignored.

Top module: `i2c_strap_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `10010` followed by the strap code. The strap code is 00 for a strap held low, 01 for a strap held high, 10 for a strap wired to SDA and 11 for a strap wired to SCL. On a mismatch SDA stays released, including for any further bytes, until the next START.
- R2: Once a matching address is received, `sda_pd_o` is high throughout the ninth SCL clock of that byte.
- R3: In a write, the byte after the address loads the pointer from its low `PTR_W` bits and is acknowledged. Each further byte is acknowledged and gives exactly one single-cycle `wr_stb_o` pulse, issued while SCL is low, with `wr_addr_o` set to the pointer and `wr_data_o` set to the byte. The pointer then increments.
- R4: When the address byte has R/W = 1, the block sends the register at the pointer MSB first and increments the pointer. Each acknowledge from the master makes it send the next register.
- R5: A master NACK after a read byte returns the block to idle, and SDA stays released for any further clocks until a START.
- R6: A STOP returns the block to idle. Bytes clocked afterwards without a START are neither acknowledged nor written.
- R7: A STOP in the same SCL high phase as the preceding START is ignored, and address reception continues.
- R8: A START or repeated START restarts address reception from any state, including after a mismatched address. It releases SDA on the next cycle, and it allows a pointer write to be followed by a read.
- R9: `sda_pd_o` never changes while the synchronized SCL stays high.
- R10: Reset clears the registers and the pointer to zero and holds `sda_pd_o` and `wr_stb_o` low.
- R11: The pointer wraps from `NREG-1` to 0, for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus) |
| strap_i | input | 1 | Address strap pin |
| sda_pd_o | output | 1 | Open-drain SDA pull-down enable |
| wr_stb_o | output | 1 | Register write strobe, one cycle |
| wr_addr_o | output | PTR_W | Register index of the write |
| wr_data_o | output | 8 | Data of the write |

## Verification
A wrong bit counter or a wrong state shows up within one byte. The ninth-clock acknowledge appears on a byte that should be ignored, or goes missing on one that should be acknowledged. A wrong strap classification is visible the same way, at the first address byte after a START. A pointer off by one stays hidden until the next read or strobe, where it appears as data from the neighbouring register or as a shifted `wr_addr_o`. A bad early-STOP rule shows up at the ninth clock of the following address byte, as a missing acknowledge.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] ADDR_UPPER = 5'b10010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int N_LINES = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] lines_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], lines_i[i]};
    end
    assign lines_o[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_strap_decode.sv
module i2c_strap_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       strap_s,
  input  logic       sda_s,
  input  logic       scl_s,
  output logic [1:0] low_bits_o
);
  logic diff_scl, diff_sda, seen_low;
  logic diff_scl_n, diff_sda_n, seen_low_n;

  always_comb begin
    if (clr_i) begin
      diff_scl_n = strap_s ^ scl_s;
      diff_sda_n = strap_s ^ sda_s;
      seen_low_n = ~strap_s;
    end else begin
      diff_scl_n = diff_scl | (strap_s ^ scl_s);
      diff_sda_n = diff_sda | (strap_s ^ sda_s);
      seen_low_n = seen_low | ~strap_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_scl <= 1'b1;
      diff_sda <= 1'b1;
      seen_low <= 1'b1;
    end else begin
      diff_scl <= diff_scl_n;
      diff_sda <= diff_sda_n;
      seen_low <= seen_low_n;
    end
  end

  always_comb begin
    if (!diff_scl)      low_bits_o = 2'b11;
    else if (!diff_sda) low_bits_o = 2'b10;
    else if (!seen_low) low_bits_o = 2'b01;
    else                low_bits_o = 2'b00;
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NREG  = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit = we_i && (waddr_i == AW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[r] <= '0;
      else if (hit) regs[r] <= wdata_i;
    end
  end

  assign rdata_o = regs[raddr_i];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_strap_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [1:0]        low_bits_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              sda_pd_o,
  output logic              wr_stb_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              start_evt_o,
  output logic              in_idle_o
);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  tgt_state_e        state, state_n;
  byte_kind_e        kind, kind_n;
  logic [3:0]        cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [PTR_W-1:0]  ptr, ptr_n, waddr_n;
  logic [BYTE_W-1:0] wdata_n;
  logic              rw, rw_n, pd_n, stb_n;
  logic              scl_q, sda_q, st_phase, st_phase_n;
  logic              scl_rise, scl_fall, start_evt, stop_evt;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

  always_comb begin
    state_n = state; kind_n = kind; cnt_n = cnt; sh_n = sh;
    ptr_n = ptr; rw_n = rw; pd_n = sda_pd_o; stb_n = 1'b0;
    waddr_n = wr_addr_o; wdata_n = wr_data_o;
    st_phase_n = start_evt ? 1'b1 : (scl_fall ? 1'b0 : st_phase);
    if (start_evt) begin
      state_n = ST_RX; kind_n = K_ADDR; cnt_n = '0; pd_n = 1'b0;
    end else if (stop_evt && !st_phase) begin
      state_n = ST_IDLE; pd_n = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && cnt < 4'd8) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            case (kind)
              K_ADDR: begin
                if (sh[7:1] == {ADDR_UPPER, low_bits_i}) begin
                  rw_n = sh[0]; pd_n = 1'b1; state_n = ST_RX_ACK;
                end else begin
                  state_n = ST_IDLE;
                end
              end
              K_PTR: begin
                ptr_n = sh[PTR_W-1:0]; pd_n = 1'b1; state_n = ST_RX_ACK;
              end
              default: begin
                stb_n = 1'b1; waddr_n = ptr; wdata_n = sh;
                ptr_n = ptr + PTR_ONE; pd_n = 1'b1; state_n = ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (kind == K_ADDR && rw) begin
              state_n = ST_TX; sh_n = rdata_i;
              ptr_n = ptr + PTR_ONE; pd_n = ~rdata_i[7];
            end else begin
              state_n = ST_RX; pd_n = 1'b0;
              kind_n  = (kind == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              pd_n = 1'b0; state_n = ST_TX_ACK;
            end else begin
              sh_n = {sh[BYTE_W-2:0], 1'b0}; pd_n = ~sh[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_s) state_n = ST_IDLE;
            else       cnt_n = 4'd9;
          end else if (scl_fall && cnt == 4'd9) begin
            cnt_n = '0; state_n = ST_TX; sh_n = rdata_i;
            ptr_n = ptr + PTR_ONE; pd_n = ~rdata_i[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; kind <= K_ADDR; cnt <= '0; sh <= '0;
      ptr <= '0; rw <= 1'b0; sda_pd_o <= 1'b0; wr_stb_o <= 1'b0;
      wr_addr_o <= '0; wr_data_o <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1; st_phase <= 1'b0;
    end else begin
      state <= state_n; kind <= kind_n; cnt <= cnt_n; sh <= sh_n;
      ptr <= ptr_n; rw <= rw_n; sda_pd_o <= pd_n; wr_stb_o <= stb_n;
      wr_addr_o <= waddr_n; wr_data_o <= wdata_n;
      scl_q <= scl_s; sda_q <= sda_s; st_phase <= st_phase_n;
    end
  end

  assign ptr_o       = ptr;
  assign start_evt_o = start_evt;
  assign in_idle_o   = (state == ST_IDLE);
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_strap_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_pd_o,
  output logic              wr_stb_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  logic [2:0]        raw_lines, sync_lines;
  logic              scl_s, sda_s, strap_s;
  logic [1:0]        low_bits;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rdata;
  logic              start_evt, in_idle;

  assign raw_lines = {strap_i, sda_i, scl_i};
  assign scl_s     = sync_lines[0];
  assign sda_s     = sync_lines[1];
  assign strap_s   = sync_lines[2];

  i2c_line_sync #(.N_LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lines_i(raw_lines), .lines_o(sync_lines)
  );

  i2c_strap_decode u_strap (
    .clk(clk), .rst_n(rst_n), .clr_i(start_evt), .strap_s(strap_s),
    .sda_s(sda_s), .scl_s(scl_s), .low_bits_o(low_bits)
  );

  i2c_reg_bank #(.NREG(NREG), .DW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(wr_stb_o), .waddr_i(wr_addr_o),
    .wdata_i(wr_data_o), .raddr_i(ptr), .rdata_o(rdata)
  );

  i2c_target_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .low_bits_i(low_bits), .rdata_i(rdata), .ptr_o(ptr),
    .sda_pd_o(sda_pd_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .start_evt_o(start_evt), .in_idle_o(in_idle)
  );
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_pd,
  input logic wr_stb,
  input logic in_idle,
  input logic start_evt
);
  p_pd_stable_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pd));

  p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_stb_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !scl_s);

  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pd);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pd);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r10: assert (!sda_pd && !wr_stb);
    end
  end
endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pd(sda_pd_o),
  .wr_stb(wr_stb_o), .in_idle(in_idle), .start_evt(start_evt)
);

// File: tb/test_i2c_strap_target.sv
`timescale 1ns/1ps
module test_i2c_strap_target;
  localparam int Q = 8;
  localparam int NV = 9;
  // {strap mode, 7-bit address sent, ack expected}
  localparam logic [9:0] ADDR_VEC [NV] = '{
    {2'd0, 7'h48, 1'b1}, {2'd0, 7'h49, 1'b0}, {2'd1, 7'h49, 1'b1},
    {2'd1, 7'h48, 1'b0}, {2'd2, 7'h4A, 1'b1}, {2'd2, 7'h4B, 1'b0},
    {2'd3, 7'h4B, 1'b1}, {2'd3, 7'h4A, 1'b0}, {2'd0, 7'h08, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, scl_m, sda_m, strap;
  logic [1:0] mode;
  logic sda_pd_o, wr_stb_o;
  logic [2:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic sda_line;
  int checks = 0, errors = 0, stb_cnt = 0;
  logic [2:0] stb_a [16];
  logic [7:0] stb_d [16];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pd_o;
  assign strap = (mode == 2'd0) ? 1'b0 : (mode == 2'd1) ? 1'b1 :
                 (mode == 2'd2) ? sda_line : scl_m;

  i2c_strap_target i_i2c_strap_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_pd_o(sda_pd_o), .wr_stb_o(wr_stb_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always @(negedge clk) begin
    if (wr_stb_o) begin
      stb_a[stb_cnt % 16] <= wr_addr_o;
      stb_d[stb_cnt % 16] <= wr_data_o;
      stb_cnt <= stb_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b0; bus_q(); bus_q(); scl_m = 1'b0; bus_q();
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; bus_q(); scl_m = 1'b1; bus_q(); bus_q();
    sda_m = 1'b0; bus_q(); bus_q(); scl_m = 1'b0; bus_q();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; bus_q(); scl_m = 1'b1; bus_q(); bus_q();
    sda_m = 1'b1; bus_q(); bus_q();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; bus_q(); scl_m = 1'b1; bus_q(); s = sda_line; bus_q();
    scl_m = 1'b0; bus_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int base;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; mode = 2'd0;
    repeat (5) @(negedge clk);
    check(!sda_pd_o && !wr_stb_o, "R10 reset outputs", {sda_pd_o, wr_stb_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1/R2: address table over strap modes
    for (int v = 0; v < NV; v++) begin
      mode = ADDR_VEC[v][9:8];
      bus_q();
      do_start();
      send_byte({ADDR_VEC[v][7:1], 1'b0}, ack);
      check(ack == ADDR_VEC[v][0], "R1 R2 address ack", ack, ADDR_VEC[v][0]);
      send_byte(8'h00, ack);
      check(ack == ADDR_VEC[v][0], "R1 second byte ack", ack, ADDR_VEC[v][0]);
      do_stop();
    end
    mode = 2'd0;
    check(stb_cnt == 0, "R3 no strobe on pointer bytes", stb_cnt, 0);

    // R10/R4/R5: read after reset returns zero, NACK releases bus
    do_start();
    send_byte(8'h91, ack);
    check(ack, "R2 read address ack", ack, 1);
    read_byte(1'b1, rb);
    check(rb == 8'h00, "R10 reg0 after reset", rb, 8'h00);
    read_byte(1'b0, rb);
    check(rb == 8'h00, "R10 reg1 after reset", rb, 8'h00);
    read_byte(1'b1, rb);
    check(rb == 8'hFF, "R5 released after NACK", rb, 8'hFF);
    do_stop();

    // R3: pointer then two data bytes
    base = stb_cnt;
    do_start();
    send_byte(8'h90, ack); send_byte(8'h02, ack);
    send_byte(8'hA5, ack);
    check(ack, "R3 data ack", ack, 1);
    send_byte(8'h3C, ack);
    do_stop();
    check(stb_cnt == base + 2, "R3 strobe count", stb_cnt, base + 2);
    check(stb_a[base % 16] == 3'd2 && stb_d[base % 16] == 8'hA5, "R3 first write",
          {stb_a[base % 16], stb_d[base % 16]}, {3'd2, 8'hA5});
    check(stb_a[(base + 1) % 16] == 3'd3 && stb_d[(base + 1) % 16] == 8'h3C, "R3 second write",
          {stb_a[(base + 1) % 16], stb_d[(base + 1) % 16]}, {3'd3, 8'h3C});

    // R8/R4: pointer write, repeated START, read
    do_start();
    send_byte(8'h90, ack); send_byte(8'h02, ack);
    do_rstart();
    send_byte(8'h91, ack);
    check(ack, "R8 read after repeated start", ack, 1);
    read_byte(1'b1, rb);
    check(rb == 8'hA5, "R4 read reg2", rb, 8'hA5);
    read_byte(1'b1, rb);
    check(rb == 8'h3C, "R4 read reg3 increment", rb, 8'h3C);
    read_byte(1'b0, rb);
    check(rb == 8'h00, "R4 read reg4", rb, 8'h00);
    do_stop();

    // R11: pointer wrap on write and read
    base = stb_cnt;
    do_start();
    send_byte(8'h90, ack); send_byte(8'h07, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack);
    check(stb_a[(base + 1) % 16] == 3'd0, "R11 write wraps to 0", stb_a[(base + 1) % 16], 0);
    do_rstart();
    send_byte(8'h90, ack); send_byte(8'h07, ack);
    do_rstart();
    send_byte(8'h91, ack);
    read_byte(1'b1, rb);
    check(rb == 8'h11, "R11 read reg7", rb, 8'h11);
    read_byte(1'b0, rb);
    check(rb == 8'h22, "R11 read wraps to reg0", rb, 8'h22);
    do_stop();

    // R8: mismatch then repeated START with matching address
    do_start();
    send_byte(8'h92, ack);
    check(!ack, "R1 mismatch no ack", ack, 0);
    do_rstart();
    send_byte(8'h90, ack);
    check(ack, "R8 restart after mismatch", ack, 1);
    send_byte(8'h05, ack); send_byte(8'h55, ack);
    base = stb_cnt;
    do_rstart();
    send_byte(8'h90, ack); send_byte(8'h06, ack); send_byte(8'h66, ack);
    do_stop();
    check(stb_cnt == base + 1 && stb_a[base % 16] == 3'd6 && stb_d[base % 16] == 8'h66,
          "R8 write after repeated start", {stb_a[base % 16], stb_d[base % 16]}, {3'd6, 8'h66});

    // R6: bytes after STOP without START are ignored
    do_start();
    send_byte(8'h90, ack); send_byte(8'h01, ack);
    do_stop();
    base = stb_cnt;
    send_byte(8'h90, ack);
    check(!ack, "R6 no ack after stop", ack, 0);
    send_byte(8'h77, ack);
    check(!ack && stb_cnt == base, "R6 no write after stop", stb_cnt, base);

    // R7: early STOP in the START high phase is ignored
    bus_q();
    sda_m = 1'b1; scl_m = 1'b1; bus_q();
    sda_m = 1'b0; bus_q(); bus_q();
    sda_m = 1'b1; bus_q(); bus_q();
    scl_m = 1'b0; bus_q();
    send_byte(8'h90, ack);
    check(ack, "R7 early stop ignored", ack, 1);
    base = stb_cnt;
    send_byte(8'h03, ack); send_byte(8'h5A, ack);
    do_stop();
    check(stb_cnt == base + 1 && stb_d[base % 16] == 8'h5A, "R7 write after early stop",
          stb_d[base % 16], 8'h5A);

    // R10: reset clears registers
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!sda_pd_o && !wr_stb_o, "R10 outputs in reset", {sda_pd_o, wr_stb_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_start();
    send_byte(8'h90, ack); send_byte(8'h02, ack);
    do_rstart();
    send_byte(8'h91, ack);
    read_byte(1'b0, rb);
    check(rb == 8'h00, "R10 reg2 cleared", rb, 8'h00);
    do_stop();

    finish_run();
  end
endmodule